// File: doc/BRIEF.md
# Segment Lookaside Table

This block is a small, fully associative table of address-segment entries used ahead of a page-table walker. Each slot holds two 64-bit words. The tag word carries the effective segment number and a valid bit. The translation word carries a segment-size field plus opaque translation, key, no-execute and large-page bits, which the block stores and returns without interpreting them.

One lookup compares an effective address against every slot in a single combinational pass. Both segment sizes, 256 MB and 1 TB, are tested in the same compare, and the lowest matching slot wins. A write port loads a slot after validating the operand. Two read ports return the tag word or the translation word of any slot. Two invalidation commands clear valid bits: one clears all slots except slot 0, the other clears the entry hit by an address. Whenever an invalidation actually clears a live entry, the block pulses a flush request to the downstream translation cache.

Word layouts:
- Tag word: bits [63:28] hold the segment tag and bit [27] is the valid bit. On a write operand, bits [11:0] select the slot.
- Translation word: bits [63:62] are the size field, where 00 means 256 MB, 01 means 1 TB, and 10 or 11 are reserved.

Top module: `seg_lookaside`

## Requirements
- R1: The lookup forms two keys, each with bit 27 set and bits [26:0] clear. The 256 MB key is {addr[63:28], valid}. The 1 TB key is {addr[63:40], twelve zero bits, valid}. A slot hits when its tag word equals the 256 MB key and its size field is 00, or when its tag word equals the 1 TB key and its size field is 01.
- R2: When several slots hit, `lk_slot` and `lk_virt` come from the lowest-numbered hitting slot.
- R3: On a miss, `lk_hit`, `lk_slot` and `lk_virt` are all zero. On a hit, `lk_virt` is the stored translation word of the hitting slot.
- R4: An accepted write goes to the slot given by `wr_tag_op[11:0]`. From the next cycle, the tag word reads back as `wr_tag_op` with bits [26:0] cleared, and the translation word reads back unchanged.
- R5: `wr_err` rises in the same cycle when `wr_en` is high and any bit of `wr_tag_op[11:0]` at a position of log2(NUM_SLOTS) or above is set.
- R6: `wr_err` rises when `wr_en` is high and the size field `wr_virt_op[63:62]` is 10 or 11.
- R7: `wr_err` rises when `wr_en` is high, the size field is 01 (1 TB), and `big_seg_en` is low.
- R8: A rejected write changes no slot.
- R9: A read whose 12-bit slot index is at or above NUM_SLOTS raises its error output and returns zero. An in-range read returns the stored word with its error output low.
- R10: `inv_all` clears bit 27 of every slot except slot 0 and leaves all other bits unchanged. Slot 0 is untouched.
- R11: One cycle after `inv_all`, `flush_req` is high only if some slot numbered 1 or above was valid before the command.
- R12: `inv_one` looks up `inv_addr` with the R1/R2 rule. On a hit, it clears bit 27 of that slot and `flush_req` is high one cycle later. On a miss, nothing changes and no flush is requested.
- R13: If several commands arrive in one cycle, only one is carried out, in the order `inv_all`, then `inv_one`, then write. `wr_err` still reports the legality of the write operand.
- R14: After synchronous reset, every word of every slot is zero and `flush_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_seg_en | input | 1 | Permits writes of 1 TB segments |
| lk_addr | input | 64 | Lookup effective address |
| lk_hit | output | 1 | Lookup hit |
| lk_slot | output | log2(NUM_SLOTS) | Lowest hitting slot |
| lk_virt | output | 64 | Translation word of the hitting slot |
| wr_en | input | 1 | Write command |
| wr_tag_op | input | 64 | Tag word operand, with the slot number in bits [11:0] |
| wr_virt_op | input | 64 | Translation word operand |
| wr_err | output | 1 | Write operand illegal |
| rdt_slot | input | 12 | Tag read slot index |
| rdt_data | output | 64 | Tag word read data |
| rdt_err | output | 1 | Tag read index out of range |
| rdv_slot | input | 12 | Translation read slot index |
| rdv_data | output | 64 | Translation word read data |
| rdv_err | output | 1 | Translation read index out of range |
| inv_all | input | 1 | Invalidate all slots except slot 0 |
| inv_one | input | 1 | Invalidate the slot hit by `inv_addr` |
| inv_addr | input | 64 | Address for `inv_one` |
| flush_req | output | 1 | One-cycle flush request after an invalidation that cleared a live entry |

## Verification
A corrupted slot shows at the ports one cycle after the write or invalidation that caused it. A read of that slot returns a different word, and a lookup on its segment gives the wrong hit, slot or translation word. A wrong priority among overlapping slots changes `lk_slot` in the same cycle as the lookup. A missed or spurious valid bit changes `flush_req` one cycle after the next invalidation. The bench therefore keeps a shadow table and compares lookup, error and read outputs every cycle, using a small pool of segment values so that overlapping and duplicate entries come up often.

// File: rtl/seglk_pkg.sv
package seglk_pkg;

    localparam int WORD_W       = 64;
    localparam int VALID_BIT    = 27;
    localparam int SEG_SMALL_LO = 28;
    localparam int SEG_BIG_LO   = 40;
    localparam int SLOT_FIELD_W = 12;
    localparam int SIZE_HI      = 63;
    localparam int SIZE_LO      = 62;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        SZ_SMALL = 2'b00,
        SZ_BIG   = 2'b01,
        SZ_RSV_A = 2'b10,
        SZ_RSV_B = 2'b11
    } seg_size_e;

    typedef struct packed {
        logic                    hit;
        logic [SLOT_FIELD_W-1:0] slot;
    } find_t;

    function automatic seg_size_e size_of(word_t virt);
        return seg_size_e'(virt[SIZE_HI:SIZE_LO]);
    endfunction

    function automatic word_t key_small(word_t addr);
        word_t k;
        k = '0;
        k[WORD_W-1:SEG_SMALL_LO] = addr[WORD_W-1:SEG_SMALL_LO];
        k[VALID_BIT] = 1'b1;
        return k;
    endfunction

    function automatic word_t key_big(word_t addr);
        word_t k;
        k = '0;
        k[WORD_W-1:SEG_BIG_LO] = addr[WORD_W-1:SEG_BIG_LO];
        k[VALID_BIT] = 1'b1;
        return k;
    endfunction

    function automatic logic entry_hits(word_t tag, word_t virt, word_t addr);
        return ((tag == key_small(addr)) && (size_of(virt) == SZ_SMALL)) ||
               ((tag == key_big(addr))   && (size_of(virt) == SZ_BIG));
    endfunction

    function automatic word_t tag_keep(word_t op);
        word_t k;
        k = op;
        k[VALID_BIT-1:0] = '0;
        return k;
    endfunction

endpackage

// File: rtl/seglk_match.sv
module seglk_match
    import seglk_pkg::*;
#(
    parameter int NUM_SLOTS = 64
) (
    input  logic [NUM_SLOTS-1:0][WORD_W-1:0] tags,
    input  logic [NUM_SLOTS-1:0][WORD_W-1:0] virts,
    input  word_t                            addr,
    output find_t                            res
);

    logic [NUM_SLOTS-1:0] hit_v;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        assign hit_v[g] = entry_hits(tags[g], virts[g], addr);
    end

    // Lowest index wins: scan downward so the last assignment is the lowest hit.
    always_comb begin
        res = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                res.hit  = 1'b1;
                res.slot = SLOT_FIELD_W'(i);
            end
        end
    end

endmodule

// File: rtl/seglk_store.sv
module seglk_store
    import seglk_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             do_write,
    input  logic [SLOT_W-1:0]                wr_slot,
    input  word_t                            wr_tag,
    input  word_t                            wr_virt,
    input  logic                             do_inv_all,
    input  logic                             do_inv_one,
    input  logic [SLOT_W-1:0]                inv_slot,
    output logic [NUM_SLOTS-1:0][WORD_W-1:0] tags_q,
    output logic [NUM_SLOTS-1:0][WORD_W-1:0] virts_q,
    output logic                             flush_q
);

    logic upper_live;
    logic flush_d;

    always_comb begin
        upper_live = 1'b0;
        for (int i = 1; i < NUM_SLOTS; i++) begin
            upper_live = upper_live | tags_q[i][VALID_BIT];
        end
    end

    assign flush_d = (do_inv_all & upper_live) | (!do_inv_all & do_inv_one);

    always_ff @(posedge clk) begin
        if (rst) begin
            tags_q  <= '0;
            virts_q <= '0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= flush_d;
            if (do_inv_all) begin
                for (int i = 1; i < NUM_SLOTS; i++) begin
                    tags_q[i][VALID_BIT] <= 1'b0;
                end
            end else if (do_inv_one) begin
                tags_q[inv_slot][VALID_BIT] <= 1'b0;
            end else if (do_write) begin
                tags_q[wr_slot]  <= wr_tag;
                virts_q[wr_slot] <= wr_virt;
            end
        end
    end

    AST_SLOT0_KEPT: assert property (@(posedge clk) disable iff (rst)
        do_inv_all |=> $stable(tags_q[0])); // R10

    AST_INV_ONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (do_inv_one && !do_inv_all) |=> !tags_q[$past(inv_slot)][VALID_BIT]); // R12

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (do_write && !do_inv_all && !do_inv_one) |=>
            (tags_q[$past(wr_slot)][VALID_BIT-1:0] == '0) &&
            (virts_q[$past(wr_slot)] == $past(wr_virt))); // R4

endmodule

// File: rtl/seg_lookaside.sv
module seg_lookaside
    import seglk_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              big_seg_en,
    input  logic [63:0]       lk_addr,
    output logic              lk_hit,
    output logic [SLOT_W-1:0] lk_slot,
    output logic [63:0]       lk_virt,
    input  logic              wr_en,
    input  logic [63:0]       wr_tag_op,
    input  logic [63:0]       wr_virt_op,
    output logic              wr_err,
    input  logic [11:0]       rdt_slot,
    output logic [63:0]       rdt_data,
    output logic              rdt_err,
    input  logic [11:0]       rdv_slot,
    output logic [63:0]       rdv_data,
    output logic              rdv_err,
    input  logic              inv_all,
    input  logic              inv_one,
    input  logic [63:0]       inv_addr,
    output logic              flush_req
);

    localparam logic [SLOT_FIELD_W-1:0] SLOT_REJECT =
        SLOT_FIELD_W'((1 << SLOT_FIELD_W) - NUM_SLOTS);
    localparam logic [SLOT_FIELD_W:0] SLOT_LIMIT = (SLOT_FIELD_W + 1)'(NUM_SLOTS);

    logic [NUM_SLOTS-1:0][WORD_W-1:0] tags_q;
    logic [NUM_SLOTS-1:0][WORD_W-1:0] virts_q;
    find_t     lk_res;
    find_t     inv_res;
    seg_size_e wr_size;
    logic      bad_slot, bad_size, bad_big;
    logic      do_write, do_inv_one;

    seglk_match #(.NUM_SLOTS(NUM_SLOTS)) u_lk_match (
        .tags  (tags_q),
        .virts (virts_q),
        .addr  (lk_addr),
        .res   (lk_res)
    );

    seglk_match #(.NUM_SLOTS(NUM_SLOTS)) u_inv_match (
        .tags  (tags_q),
        .virts (virts_q),
        .addr  (inv_addr),
        .res   (inv_res)
    );

    // Write operand legality
    assign wr_size  = size_of(wr_virt_op);
    assign bad_slot = |(wr_tag_op[SLOT_FIELD_W-1:0] & SLOT_REJECT);
    assign bad_size = (wr_size == SZ_RSV_A) || (wr_size == SZ_RSV_B);
    assign bad_big  = (wr_size == SZ_BIG) && !big_seg_en;
    assign wr_err   = wr_en & (bad_slot | bad_size | bad_big);

    // Command arbitration: inv_all, then inv_one, then write
    assign do_inv_one = inv_one & !inv_all & inv_res.hit;
    assign do_write   = wr_en & !wr_err & !inv_all & !inv_one;

    seglk_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .do_write   (do_write),
        .wr_slot    (wr_tag_op[SLOT_W-1:0]),
        .wr_tag     (tag_keep(wr_tag_op)),
        .wr_virt    (wr_virt_op),
        .do_inv_all (inv_all),
        .do_inv_one (do_inv_one),
        .inv_slot   (inv_res.slot[SLOT_W-1:0]),
        .tags_q     (tags_q),
        .virts_q    (virts_q),
        .flush_q    (flush_req)
    );

    // Lookup outputs
    assign lk_hit  = lk_res.hit;
    assign lk_slot = lk_res.slot[SLOT_W-1:0];
    assign lk_virt = lk_res.hit ? virts_q[lk_res.slot[SLOT_W-1:0]] : '0;

    // Read ports
    assign rdt_err  = {1'b0, rdt_slot} >= SLOT_LIMIT;
    assign rdv_err  = {1'b0, rdv_slot} >= SLOT_LIMIT;
    assign rdt_data = rdt_err ? '0 : tags_q[rdt_slot[SLOT_W-1:0]];
    assign rdv_data = rdv_err ? '0 : virts_q[rdv_slot[SLOT_W-1:0]];

    AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> tags_q[lk_slot][VALID_BIT]); // R1

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_err && !inv_all && !inv_one) |=>
            ($stable(tags_q) && $stable(virts_q))); // R8

    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> $past(inv_all || inv_one)); // R11

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_virt == '0) && (lk_slot == '0)); // R3

endmodule

// File: tb/seg_lookaside_tb_top.sv
`timescale 1ns/1ps
module seg_lookaside_tb_top;

    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        big_seg_en = 1'b1;
    logic [63:0] lk_addr = '0;
    logic        lk_hit;
    logic [5:0]  lk_slot;
    logic [63:0] lk_virt;
    logic        wr_en = 1'b0;
    logic [63:0] wr_tag_op = '0;
    logic [63:0] wr_virt_op = '0;
    logic        wr_err;
    logic [11:0] rdt_slot = '0;
    logic [63:0] rdt_data;
    logic        rdt_err;
    logic [11:0] rdv_slot = '0;
    logic [63:0] rdv_data;
    logic        rdv_err;
    logic        inv_all = 1'b0;
    logic        inv_one = 1'b0;
    logic [63:0] inv_addr = '0;
    logic        flush_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] m_tag  [N];
    logic [63:0] m_virt [N];
    bit          exp_flush = 0;

    logic [35:0] pool [6];

    always #4 clk = ~clk;

    seg_lookaside #(.NUM_SLOTS(N)) dut_i (
        .clk(clk), .rst(rst), .big_seg_en(big_seg_en),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_virt(lk_virt),
        .wr_en(wr_en), .wr_tag_op(wr_tag_op), .wr_virt_op(wr_virt_op), .wr_err(wr_err),
        .rdt_slot(rdt_slot), .rdt_data(rdt_data), .rdt_err(rdt_err),
        .rdv_slot(rdv_slot), .rdv_data(rdv_data), .rdv_err(rdv_err),
        .inv_all(inv_all), .inv_one(inv_one), .inv_addr(inv_addr),
        .flush_req(flush_req)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected lookup from the R1/R2 rule on the shadow table
    function automatic void model_find(input logic [63:0] a, output bit h, output int s);
        logic [63:0] ks, kb;
        ks = {a[63:28], 1'b1, 27'd0};
        kb = {a[63:40], 12'd0, 1'b1, 27'd0};
        h = 0;
        s = 0;
        for (int i = 0; i < N; i++) begin
            if (!h && (((m_tag[i] == ks) && (m_virt[i][63:62] == 2'b00)) ||
                       ((m_tag[i] == kb) && (m_virt[i][63:62] == 2'b01)))) begin
                h = 1;
                s = i;
            end
        end
    endfunction

    function automatic bit model_wr_bad(input logic [63:0] t, input logic [63:0] v, input logic big);
        return (|t[11:6]) || v[63] || ((v[63:62] == 2'b01) && !big);
    endfunction

    function automatic logic [63:0] rand_addr();
        logic [63:0] a;
        a = {pool[$urandom % 6], 28'($urandom)};
        if ($urandom % 8 == 0) a = {$urandom, $urandom};
        return a;
    endfunction

    // One clock cycle: called at a negedge with inputs already driven.
    task automatic run_cycle();
        bit h;
        int s;
        bit bad;
        #1;
        model_find(lk_addr, h, s);
        chk("R1 R2 R3 lk_hit", 64'(lk_hit), 64'(h));
        chk("R2 R3 lk_slot", 64'(lk_slot), 64'(s));
        chk("R3 lk_virt", lk_virt, h ? m_virt[s] : 64'd0);
        bad = model_wr_bad(wr_tag_op, wr_virt_op, big_seg_en);
        if (wr_en) chk("R5 R6 R7 R13 wr_err", 64'(wr_err), 64'(bad));
        chk("R9 rdt_err", 64'(rdt_err), 64'(rdt_slot >= 12'(N)));
        chk("R4 R9 R10 R12 rdt_data", rdt_data, (rdt_slot < 12'(N)) ? m_tag[rdt_slot[5:0]] : 64'd0);
        chk("R9 rdv_err", 64'(rdv_err), 64'(rdv_slot >= 12'(N)));
        chk("R4 R8 R9 rdv_data", rdv_data, (rdv_slot < 12'(N)) ? m_virt[rdv_slot[5:0]] : 64'd0);
        @(posedge clk);
        exp_flush = 0;
        if (inv_all) begin
            for (int i = 1; i < N; i++) begin
                if (m_tag[i][27]) exp_flush = 1;
                m_tag[i][27] = 1'b0;
            end
        end else if (inv_one) begin
            model_find(inv_addr, h, s);
            if (h) begin
                m_tag[s][27] = 1'b0;
                exp_flush = 1;
            end
        end else if (wr_en && !bad) begin
            m_tag[wr_tag_op[5:0]]  = {wr_tag_op[63:27], 27'd0};
            m_virt[wr_tag_op[5:0]] = wr_virt_op;
        end
        @(negedge clk);
        chk("R11 R12 flush_req", 64'(flush_req), 64'(exp_flush));
        wr_en = 0;
        inv_all = 0;
        inv_one = 0;
    endtask

    task automatic do_write(input int slot, input logic [35:0] seg, input bit v, input logic [1:0] sz);
        wr_en = 1;
        wr_tag_op = {seg, v, 15'd0, 12'(slot)};
        wr_virt_op = {sz, 30'h1234567, 32'(slot)};
        run_cycle();
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < N; i++) begin
            rdt_slot = 12'(i);
            rdv_slot = 12'(i);
            #1;
            chk(req, rdt_data, m_tag[i]);
            chk(req, rdv_data, m_virt[i]);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        pool[0] = 36'h123456000;
        pool[1] = 36'h123456001;
        pool[2] = 36'hABCDE0000;
        pool[3] = 36'h000000000;
        pool[4] = 36'hFFFFFFFFF;
        pool[5] = 36'h0F0F0F0F0;
        for (int i = 0; i < N; i++) begin
            m_tag[i] = '0;
            m_virt[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk("R14 flush after reset", 64'(flush_req), 64'd0);
        sweep("R14 reset contents");

        // R2: duplicate 256 MB entries, lowest slot wins
        do_write(5, pool[2], 1, 2'b00);
        do_write(2, pool[2], 1, 2'b00);
        lk_addr = {pool[2], 28'h0ABCDEF};
        #1;
        chk("R2 lowest slot", 64'(lk_slot), 64'd2);
        // R1: 1 TB entry at slot 1 matches an address differing in bits 39:28
        do_write(1, pool[0], 1, 2'b01);
        lk_addr = {pool[1], 28'h1};
        #1;
        chk("R1 big segment hit", 64'(lk_hit), 64'd1);
        chk("R1 big segment slot", 64'(lk_slot), 64'd1);
        // R4: slot bits and low bits cleared when stored
        wr_en = 1; wr_tag_op = {pool[5], 1'b1, 15'h7FFF, 12'd9}; wr_virt_op = 64'h0000_0000_DEAD_BEEF;
        run_cycle();
        rdt_slot = 12'd9;
        #1;
        chk("R4 stored tag masked", rdt_data, {pool[5], 1'b1, 27'd0});
        // R5, R6, R7 and R8
        wr_en = 1; wr_tag_op = {pool[3], 1'b1, 15'd0, 12'd64}; wr_virt_op = '0;
        #1; chk("R5 reserved slot bit", 64'(wr_err), 64'd1);
        run_cycle();
        wr_en = 1; wr_tag_op = {pool[3], 1'b1, 15'd0, 12'd7}; wr_virt_op = {2'b10, 62'd0};
        #1; chk("R6 reserved size", 64'(wr_err), 64'd1);
        run_cycle();
        big_seg_en = 0;
        wr_en = 1; wr_tag_op = {pool[3], 1'b1, 15'd0, 12'd7}; wr_virt_op = {2'b01, 62'd0};
        #1; chk("R7 big disabled", 64'(wr_err), 64'd1);
        run_cycle();
        big_seg_en = 1;
        sweep("R8 rejected writes change nothing");
        // R9: out of range read
        rdt_slot = 12'd64; rdv_slot = 12'hFFF;
        #1;
        chk("R9 out of range tag", {rdt_data[62:0], rdt_err}, 64'd1);
        chk("R9 out of range virt", {rdv_data[62:0], rdv_err}, 64'd1);
        // R13: inv_one beats a write in the same cycle
        do_write(0, pool[4], 1, 2'b00);
        wr_en = 1; wr_tag_op = {pool[3], 1'b1, 15'd0, 12'd20}; wr_virt_op = '0;
        inv_one = 1; inv_addr = {pool[4], 28'd5};
        run_cycle();
        rdt_slot = 12'd20;
        #1;
        chk("R13 write pre-empted", rdt_data, 64'd0);
        chk("R12 hit cleared slot 0 valid", 64'(m_tag[0][27]), 64'd0);
        // R12 miss
        inv_one = 1; inv_addr = {pool[4], 28'd5};
        run_cycle();
        // R10 / R11
        do_write(0, pool[4], 1, 2'b00);
        inv_all = 1;
        run_cycle();
        chk("R11 flush after live inv_all", 64'(exp_flush), 64'd1);
        rdt_slot = 12'd0;
        #1;
        chk("R10 slot 0 kept", 64'(rdt_data[27]), 64'd1);
        inv_all = 1;
        run_cycle();
        chk("R11 no flush when nothing live", 64'(flush_req), 64'd0);

        // Constrained random
        for (int n = 0; n < 4000; n++) begin
            int op;
            op = $urandom % 16;
            lk_addr  = rand_addr();
            rdt_slot = ($urandom % 8 == 0) ? 12'($urandom) : 12'($urandom % N);
            rdv_slot = ($urandom % 8 == 0) ? 12'($urandom) : 12'($urandom % N);
            if ($urandom % 64 == 0) big_seg_en = ~big_seg_en;
            if (op < 9) begin
                int sz;
                sz = $urandom % 20;
                wr_en = 1;
                wr_tag_op = {pool[$urandom % 6], 1'($urandom % 4 != 0), 15'($urandom),
                             ($urandom % 10 == 0) ? 12'($urandom) : 12'($urandom % N)};
                wr_virt_op = {(sz < 10) ? 2'b00 : (sz < 17) ? 2'b01 : 2'($urandom),
                              30'($urandom), 32'($urandom)};
            end
            if (op >= 9 && op < 14 || op == 15) begin
                inv_one = 1;
                inv_addr = rand_addr();
            end
            if (op == 14 || (op == 15 && $urandom % 2 == 0)) inv_all = 1;
            run_cycle();
        end
        sweep("R4 R10 R12 final contents");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule